// File: doc/BRIEF.md
# Exception Priority Masking Unit

This block holds the interrupt masking state of a small processor core and decides, for one candidate exception at a time, whether that exception may be taken. There are three masking mechanisms. A one-bit global mask blocks the ordinary exceptions. A one-bit fault mask blocks everything except the non-maskable interrupt. A priority threshold blocks ordinary exceptions whose priority number is at or above the threshold. A threshold of zero switches the threshold check off.

Software reaches all three registers only through a special-register port, which has a select, a write strobe, write data and a combinational read-back. Separate set and clear strobes change the two one-bit masks directly. The exception controller presents the class and priority number of a candidate exception. The unit answers on a combinational permit output, which is computed from the current register contents. A register change therefore shows on the permit output from the cycle after the clock edge that performs it.

Top module: `epm_unit`

## Requirements
- R1: After reset, all three registers read 0. A 0 threshold, as after reset, blocks nothing.
- R2: When `reg_wr` is high at a rising edge, the register chosen by `reg_sel` is loaded from `reg_wdata`. The select encoding is 0 = global mask (bit 0), 1 = fault mask (bit 0), 2 = threshold (all bits) and 3 = none. The new value appears on `reg_rdata` and acts on `exc_permit` from the next cycle on. With no write and no strobe, every register holds its value.
- R3: `reg_rdata` shows the selected register without delay. A one-bit mask reads in bit 0, with the upper bits zero. Select 3 reads 0, and a write to select 3 changes no register.
- R4: A disable strobe (`gmask_dis`, `fmask_dis`) sets its mask to 1. An enable strobe (`gmask_en`, `fmask_en`) clears it to 0. When both strobes of one mask are high together, the mask becomes 1.
- R5: A strobe takes precedence over a port write to the same mask in the same cycle.
- R6: An exception of class 2 (NMI) is always permitted, whatever the register contents.
- R7: With the fault mask at 1, every exception except class 2 is refused.
- R8: With the global mask at 1 and the fault mask at 0, class 1 (hard fault) is permitted. Class 0 (ordinary) and class 3 are refused; class 3 is handled as ordinary.
- R9: With a nonzero threshold and both one-bit masks at 0, an ordinary exception (class 0 or 3) is refused when `exc_prio >= threshold` and permitted when `exc_prio < threshold`.
- R10: The threshold never affects class 1 or class 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 2 | Register select: 0 global mask, 1 fault mask, 2 threshold, 3 none |
| reg_wdata | input | PRIO_W | Register port write data |
| reg_rdata | output | PRIO_W | Combinational read-back of the selected register |
| gmask_dis | input | 1 | Sets the global mask |
| gmask_en | input | 1 | Clears the global mask |
| fmask_dis | input | 1 | Sets the fault mask |
| fmask_en | input | 1 | Clears the fault mask |
| exc_class | input | 2 | Candidate class: 0 ordinary, 1 hard fault, 2 NMI, 3 treated as ordinary |
| exc_prio | input | PRIO_W | Candidate priority number |
| exc_permit | output | 1 | High when the candidate may be taken |

## Verification
A wrong bit in any mask register shows at the ports in two ways. It appears on `reg_rdata` in the same cycle that register is selected. It also changes `exc_permit` for some class and priority pair in that same cycle. The bench therefore rotates the read select and sweeps every class against the whole priority range under several register settings. It compares both outputs against a behavioural model on every clock, so a corrupted state is caught at the first cycle it exists. Strobe and write collisions are exercised in dedicated cycles, so a wrong precedence shows on the very next read-back.

// File: rtl/epm_pkg.sv
package epm_pkg;
  typedef enum logic [1:0] {
    EXC_ORD  = 2'd0,
    EXC_HARD = 2'd1,
    EXC_NMI  = 2'd2,
    EXC_RSV  = 2'd3
  } exc_class_e;

  typedef enum logic [1:0] {
    SEL_GMASK  = 2'd0,
    SEL_FMASK  = 2'd1,
    SEL_THRESH = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_BITMASKS = 2;
  localparam int unsigned IDX_GMASK    = 0;
  localparam int unsigned IDX_FMASK    = 1;
endpackage

// File: rtl/epm_rst_sync.sv
module epm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/epm_mask_regs.sv
module epm_mask_regs
  import epm_pkg::*;
#(
  parameter int unsigned PRIO_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [1:0]              sel_i,
  input  logic [PRIO_W-1:0]       wdata_i,
  input  logic [NUM_BITMASKS-1:0] dis_i,
  input  logic [NUM_BITMASKS-1:0] en_i,
  output logic [NUM_BITMASKS-1:0] bits_o,
  output logic [PRIO_W-1:0]       thr_o,
  output logic [PRIO_W-1:0]       rdata_o
);
  localparam logic [1:0] BIT_SEL [NUM_BITMASKS] = '{SEL_GMASK, SEL_FMASK};

  logic [NUM_BITMASKS-1:0] bits_q;
  logic [NUM_BITMASKS-1:0] bits_d;
  logic [NUM_BITMASKS-1:0] bits_ce;
  logic [PRIO_W-1:0]       thr_q;
  logic [PRIO_W-1:0]       thr_d;
  logic                    thr_ce;

  for (genvar g = 0; g < NUM_BITMASKS; g++) begin : g_bitmask
    logic port_hit;
    assign port_hit = wr_i && (sel_i == BIT_SEL[g]);

    always_comb begin
      bits_ce[g] = port_hit || dis_i[g] || en_i[g];
      if (dis_i[g])     bits_d[g] = 1'b1;
      else if (en_i[g]) bits_d[g] = 1'b0;
      else              bits_d[g] = wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)         bits_q[g] <= 1'b0;
      else if (bits_ce[g]) bits_q[g] <= bits_d[g];
    end

    p_dis_sets_r4: assert property (@(posedge clk) disable iff (!rst_ni)
      dis_i[g] |=> bits_q[g]);
    p_en_clears_r4: assert property (@(posedge clk) disable iff (!rst_ni)
      (en_i[g] && !dis_i[g]) |=> !bits_q[g]);
    p_strobe_over_port_r5: assert property (@(posedge clk) disable iff (!rst_ni)
      (port_hit && (dis_i[g] || en_i[g])) |=> (bits_q[g] == $past(dis_i[g])));
  end

  always_comb begin
    thr_ce = wr_i && (sel_i == SEL_THRESH);
    thr_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     thr_q <= '0;
    else if (thr_ce) thr_q <= thr_d;
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(sel_i))
      SEL_GMASK:  rdata_o[0] = bits_q[IDX_GMASK];
      SEL_FMASK:  rdata_o[0] = bits_q[IDX_FMASK];
      SEL_THRESH: rdata_o    = thr_q;
      SEL_NONE:   rdata_o    = '0;
    endcase
  end

  assign bits_o = bits_q;
  assign thr_o  = thr_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!wr_i && !(|dis_i) && !(|en_i)) |=> ($stable(bits_q) && $stable(thr_q)));
  p_thr_load_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_THRESH) |=> (thr_q == $past(wdata_i)));
  p_none_sel_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_NONE && !(|dis_i) && !(|en_i))
      |=> ($stable(bits_q) && $stable(thr_q)));
endmodule

// File: rtl/epm_permit_gate.sv
module epm_permit_gate
  import epm_pkg::*;
#(
  parameter int unsigned PRIO_W = 9
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              gmask_i,
  input  logic              fmask_i,
  input  logic [PRIO_W-1:0] thr_i,
  input  logic [1:0]        class_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic              permit_o
);
  logic is_nmi;
  logic is_hard;
  logic is_ord;
  logic thr_active;
  logic thr_block;

  always_comb begin
    is_nmi     = (class_i == EXC_NMI);
    is_hard    = (class_i == EXC_HARD);
    is_ord     = !is_nmi && !is_hard;
    thr_active = |thr_i;
    thr_block  = thr_active && (prio_i >= thr_i);
    if (is_nmi)       permit_o = 1'b1;
    else if (fmask_i) permit_o = 1'b0;
    else if (is_hard) permit_o = 1'b1;
    else              permit_o = !gmask_i && !thr_block;
  end

  p_nmi_always_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (class_i == EXC_NMI) |-> permit_o);
  p_fault_blocks_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (fmask_i && class_i != EXC_NMI) |-> !permit_o);
  p_gmask_ord_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (gmask_i && is_ord) |-> !permit_o);
  p_thr_block_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (is_ord && thr_i != '0 && prio_i >= thr_i) |-> !permit_o);
  p_hard_free_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (class_i == EXC_HARD && !fmask_i) |-> permit_o);
endmodule

// File: rtl/epm_unit.sv
module epm_unit
  import epm_pkg::*;
#(
  parameter int unsigned PRIO_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [PRIO_W-1:0] reg_wdata,
  output logic [PRIO_W-1:0] reg_rdata,
  input  logic              gmask_dis,
  input  logic              gmask_en,
  input  logic              fmask_dis,
  input  logic              fmask_en,
  input  logic [1:0]        exc_class,
  input  logic [PRIO_W-1:0] exc_prio,
  output logic              exc_permit
);
  logic                    rst_sync_n;
  logic [NUM_BITMASKS-1:0] dis_vec;
  logic [NUM_BITMASKS-1:0] en_vec;
  logic [NUM_BITMASKS-1:0] bits;
  logic [PRIO_W-1:0]       thr;

  always_comb begin
    dis_vec            = '0;
    en_vec             = '0;
    dis_vec[IDX_GMASK] = gmask_dis;
    dis_vec[IDX_FMASK] = fmask_dis;
    en_vec[IDX_GMASK]  = gmask_en;
    en_vec[IDX_FMASK]  = fmask_en;
  end

  epm_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  epm_mask_regs #(.PRIO_W(PRIO_W)) i_regs (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .wr_i    (reg_wr),
    .sel_i   (reg_sel),
    .wdata_i (reg_wdata),
    .dis_i   (dis_vec),
    .en_i    (en_vec),
    .bits_o  (bits),
    .thr_o   (thr),
    .rdata_o (reg_rdata)
  );

  epm_permit_gate #(.PRIO_W(PRIO_W)) i_gate (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .gmask_i  (bits[IDX_GMASK]),
    .fmask_i  (bits[IDX_FMASK]),
    .thr_i    (thr),
    .class_i  (exc_class),
    .prio_i   (exc_prio),
    .permit_o (exc_permit)
  );
endmodule

// File: tb/test_epm_unit.sv
module test_epm_unit;
  localparam int CLK_P  = 10;
  localparam int PRIO_W = 9;
  localparam int PMAX   = (1 << PRIO_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [1:0]        reg_sel;
  logic [PRIO_W-1:0] reg_wdata;
  logic [PRIO_W-1:0] reg_rdata;
  logic              gmask_dis, gmask_en, fmask_dis, fmask_en;
  logic [1:0]        exc_class;
  logic [PRIO_W-1:0] exc_prio;
  logic              exc_permit;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  int m_g = 0, m_f = 0, m_t = 0;

  always #(CLK_P/2) clk = ~clk;

  epm_unit #(.PRIO_W(PRIO_W)) i_epm_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gmask_dis(gmask_dis), .gmask_en(gmask_en),
    .fmask_dis(fmask_dis), .fmask_en(fmask_en),
    .exc_class(exc_class), .exc_prio(exc_prio), .exc_permit(exc_permit)
  );

  function automatic int exp_rdata(int sel);
    case (sel)
      0: return m_g;
      1: return m_f;
      2: return m_t;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_permit(int cls, int prio);
    if (cls == 2) return 1;
    if (m_f != 0) return 0;
    if (cls == 1) return 1;
    if (m_g != 0) return 0;
    if (m_t != 0 && prio >= m_t) return 0;
    return 1;
  endfunction

  task automatic idle_inputs();
    reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    gmask_dis = 0; gmask_en = 0; fmask_dis = 0; fmask_en = 0;
    exc_class = 0; exc_prio = '0;
  endtask

  // Called at a falling edge with inputs already driven.
  task automatic step(string tag);
    int er, ep;
    #1;
    er = exp_rdata(int'(reg_sel));
    ep = exp_permit(int'(exc_class), int'(exc_prio));
    checks++;
    if (int'(reg_rdata) != er) begin
      failures++;
      $display("FAIL %s reg_rdata sel=%0d act=%0h exp=%0h", tag, reg_sel, reg_rdata, er);
    end
    checks++;
    if (int'(exc_permit) != ep) begin
      failures++;
      $display("FAIL %s exc_permit cls=%0d prio=%0d act=%0d exp=%0d",
               tag, exc_class, exc_prio, exc_permit, ep);
    end
    @(posedge clk);
    if (reg_wr) begin
      case (int'(reg_sel))
        0: m_g = int'(reg_wdata[0]);
        1: m_f = int'(reg_wdata[0]);
        2: m_t = int'(reg_wdata);
        default: ;
      endcase
    end
    if (gmask_dis) m_g = 1; else if (gmask_en) m_g = 0;
    if (fmask_dis) m_f = 1; else if (fmask_en) m_f = 0;
    @(negedge clk);
  endtask

  task automatic wr(int sel, int val, string tag);
    idle_inputs();
    reg_wr = 1; reg_sel = 2'(sel); reg_wdata = PRIO_W'(val);
    step(tag);
    idle_inputs();
    reg_sel = 2'(sel);
    step(tag);
  endtask

  task automatic sweep(string tag);
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p <= PMAX; p++) begin
        idle_inputs();
        exc_class = 2'(c); exc_prio = PRIO_W'(p); reg_sel = 2'(p % 4);
        step(tag);
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      reg_sel = 2'(i % 4); exc_class = 0; exc_prio = PRIO_W'(PMAX);
      step("R1 reset");
    end
    sweep("R1 R6 R10 zero-regs");

    wr(2, 9'h1A5, "R2 thr write");
    wr(2, 100, "R2 thr write");
    sweep("R9 R10 thr=100");
    wr(2, 1, "R2 thr write");
    sweep("R9 thr=1");
    wr(2, PMAX, "R2 thr write");
    sweep("R9 thr=max");
    wr(3, 9'h055, "R3 none select");
    for (int s = 0; s < 4; s++) begin
      idle_inputs(); reg_sel = 2'(s); step("R3 none select");
    end
    wr(2, 0, "R2 thr write");

    wr(0, 9'h1FF, "R2 gmask write");
    wr(0, 9'h1FE, "R2 gmask write");
    wr(0, 1, "R2 gmask write");
    sweep("R8 gmask");
    wr(2, 50, "R2 thr write");
    sweep("R8 gmask thr");
    wr(0, 0, "R2 gmask write");
    wr(1, 1, "R2 fmask write");
    sweep("R7 fmask");

    idle_inputs(); fmask_en = 1; reg_sel = 1; step("R4 en");
    idle_inputs(); reg_sel = 1; step("R4 en");
    idle_inputs(); gmask_dis = 1; reg_sel = 0; step("R4 dis");
    idle_inputs(); reg_sel = 0; step("R4 dis");
    idle_inputs(); gmask_en = 1; reg_sel = 0; step("R4 en");
    idle_inputs(); reg_sel = 0; step("R4 en");
    idle_inputs(); gmask_en = 1; gmask_dis = 1; reg_sel = 0; step("R4 both");
    idle_inputs(); reg_sel = 0; step("R4 both");
    idle_inputs(); fmask_en = 1; fmask_dis = 1; reg_sel = 1; step("R4 both");
    idle_inputs(); reg_sel = 1; step("R4 both");
    sweep("R7 R8 both masks");

    idle_inputs(); reg_wr = 1; reg_sel = 0; reg_wdata = 0; gmask_dis = 1;
    gmask_en = 1; step("R5 dis over write");
    idle_inputs(); reg_wr = 1; reg_sel = 1; reg_wdata = 1; fmask_en = 1;
    step("R5 en over write");
    for (int s = 0; s < 3; s++) begin
      idle_inputs(); reg_sel = 2'(s); step("R5 readback");
    end
    idle_inputs(); reg_wr = 1; reg_sel = 0; reg_wdata = 1; gmask_en = 1;
    step("R5 en over write");
    idle_inputs(); reg_sel = 0; step("R5 readback");
    sweep("R9 R10 thr=50");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule